// File: doc/BRIEF.md
# Sync Normalizer and Crop DE Generator

This block sits in a video capture path directly behind the pixel input pins. It watches the raw horizontal and vertical sync lines, works out whether each one is active high or active low, reports that finding on two status outputs, and always hands the syncs on as active high. Video data travels alongside the syncs with a fixed latency.

Analog sources give no data enable. For those, the block counts pixels from the horizontal sync edge and lines from the vertical sync edge. It raises DE inside a rectangle that four 16-bit controls program: first column, column count, first row and row count. An 800x600 raster might use first column 0x59, 0x320 columns, first row 0x1B and 0x258 rows. A 1024x768 raster might use 0xA1, 0x400, 0x24 and 0x300. Once the source has driven its own DE high, the window is abandoned and the source DE is forwarded until the next reset.

Top module: `vid_sync_crop`

## Requirements
- R1: `out_hs` and `out_vs` are active high for every combination of input sync polarities. A sync pulse shorter than half its period therefore always appears as a high pulse on the output.
- R2: Each polarity status output becomes 1 when its raw sync is high for more than half of one period, and 0 otherwise. A period runs from one raw rising edge to the next. The result is held until the next full period has been measured.
- R3: The column position is 0 for the pixel at which the normalized HS rises, and goes up by one on every following pixel.
- R4: The row position is 0 for the line on which the normalized VS rises. It goes up by one at every later normalized HS rising edge.
- R5: While window mode is in use, `out_de` is 1 exactly when both of these hold: `cfg_x0 <= column < cfg_x0 + cfg_w` and `cfg_y0 <= row < cfg_y0 + cfg_h`. Both lower bounds are inclusive and both upper bounds are exclusive.
- R6: From the first pixel on which `in_de` is 1 until the next reset, `out_de` follows `in_de` and the window has no effect. Reset returns the block to window mode.
- R7: `out_pix`, `out_hs`, `out_vs` and `out_de` all show the pixel presented on the inputs two clock edges earlier.
- R8: While `rst_n` is low, all outputs are 0, including both polarity status outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vs | input | 1 | Raw vertical sync, any polarity |
| in_hs | input | 1 | Raw horizontal sync, any polarity |
| in_de | input | 1 | Source data enable; held 0 by sources without one |
| in_pix | input | DAT_W | Pixel data |
| cfg_x0 | input | POS_W | First active column |
| cfg_w | input | POS_W | Active columns per line |
| cfg_y0 | input | POS_W | First active row |
| cfg_h | input | POS_W | Active rows per frame |
| out_vs | output | 1 | Vertical sync, active high |
| out_hs | output | 1 | Horizontal sync, active high |
| out_de | output | 1 | Data enable (window or pass-through) |
| out_pix | output | DAT_W | Pixel data, aligned with syncs and DE |
| det_vs_pol | output | 1 | 1 = raw VS measured active low |
| det_hs_pol | output | 1 | 1 = raw HS measured active low |

## Verification
A small raster of 20 columns by 12 lines is driven under all four combinations of raw HS and VS polarity. Each output pixel is compared against a position computed from its frame, line and column. This shows whether the polarity decision, the normalization and both counters agree on where a line and a frame begin. Further windows test the edges of the rectangle: column 0, a single column, and the last row. A source DE shaped differently from the window shows whether pass-through takes over, and a window run after a reset shows that the mode does not survive the reset.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int POS_W = 16;

    typedef struct packed {
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
    } pos_t;
endpackage

// File: rtl/sync_pol_meas.sv
module sync_pol_meas #(
    parameter int MEAS_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic pol_o
);
    typedef struct packed {
        logic              prev;
        logic              armed;
        logic              pol;
        logic [MEAS_W-1:0] hi;
        logic [MEAS_W-1:0] lo;
    } st_t;

    localparam logic [MEAS_W-1:0] CNT_MAX = '1;

    st_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        rise      = sync_i & ~st_q.prev;
        st_d.prev = sync_i;
        if (rise) begin
            if (st_q.armed) st_d.pol = (st_q.hi > st_q.lo);
            st_d.armed = 1'b1;
            st_d.hi    = MEAS_W'(1);
            st_d.lo    = '0;
        end else if (sync_i) begin
            if (st_q.hi != CNT_MAX) st_d.hi = st_q.hi + 1'b1;
        end else begin
            if (st_q.lo != CNT_MAX) st_d.lo = st_q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_o = st_q.pol;

    // R2: the decision only moves after a period boundary
    assert_pol_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pol) |-> $past(rise));
endmodule

// File: rtl/raster_pos.sv
module raster_pos
    import vsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_n,
    input  logic vs_n,
    output pos_t pos_o
);
    typedef struct packed {
        logic hs_prev;
        logic vs_prev;
        pos_t pos;
    } st_t;

    localparam logic [POS_W-1:0] POS_MAX = '1;

    st_t  st_d, st_q;
    logic hs_rise, vs_rise;

    always_comb begin
        st_d         = st_q;
        hs_rise      = hs_n & ~st_q.hs_prev;
        vs_rise      = vs_n & ~st_q.vs_prev;
        st_d.hs_prev = hs_n;
        st_d.vs_prev = vs_n;
        if (hs_rise)                    st_d.pos.x = '0;
        else if (st_q.pos.x != POS_MAX) st_d.pos.x = st_q.pos.x + 1'b1;
        if (vs_rise)                    st_d.pos.y = '0;
        else if (hs_rise && st_q.pos.y != POS_MAX)
                                        st_d.pos.y = st_q.pos.y + 1'b1;
        pos_o = st_d.pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hs_prev <= 1'b0;
            st_q.vs_prev <= 1'b0;
            st_q.pos.x   <= POS_MAX;
            st_q.pos.y   <= POS_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a column run never jumps by more than one unless a line starts
    assert_x_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && st_q.pos.x != POS_MAX) |=> (st_q.pos.x == $past(st_q.pos.x) + 1'b1));
    // R4: rows stay put inside a line
    assert_y_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && !vs_rise) |=> $stable(st_q.pos.y));
endmodule

// File: rtl/crop_window.sv
module crop_window
    import vsc_pkg::*;
(
    input  pos_t             pos_i,
    input  logic [POS_W-1:0] x0,
    input  logic [POS_W-1:0] w,
    input  logic [POS_W-1:0] y0,
    input  logic [POS_W-1:0] h,
    output logic             in_win
);
    logic [POS_W:0] x_end, y_end;
    logic           x_ok, y_ok;

    always_comb begin
        x_end  = {1'b0, x0} + {1'b0, w};
        y_end  = {1'b0, y0} + {1'b0, h};
        x_ok   = (pos_i.x >= x0) && ({1'b0, pos_i.x} < x_end);
        y_ok   = (pos_i.y >= y0) && ({1'b0, pos_i.y} < y_end);
        in_win = x_ok && y_ok;
    end
endmodule

// File: rtl/vid_sync_crop.sv
module vid_sync_crop
    import vsc_pkg::*;
#(
    parameter int DAT_W  = 24,
    parameter int MEAS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vs,
    input  logic             in_hs,
    input  logic             in_de,
    input  logic [DAT_W-1:0] in_pix,
    input  logic [POS_W-1:0] cfg_x0,
    input  logic [POS_W-1:0] cfg_w,
    input  logic [POS_W-1:0] cfg_y0,
    input  logic [POS_W-1:0] cfg_h,
    output logic             out_vs,
    output logic             out_hs,
    output logic             out_de,
    output logic [DAT_W-1:0] out_pix,
    output logic             det_vs_pol,
    output logic             det_hs_pol
);
    localparam int N_SYNC = 2;   // index 0 = HS, 1 = VS

    typedef struct packed {
        logic             vs;
        logic             hs;
        logic             de;
        logic [DAT_W-1:0] pix;
    } beat_t;

    typedef struct packed {
        beat_t cap;
        beat_t outb;
        logic  ext_de;
    } st_t;

    st_t  st_d, st_q;
    logic [N_SYNC-1:0] raw_sync, pol;
    logic hs_n, vs_n, win;
    pos_t pos_cur;

    assign raw_sync = {st_q.cap.vs, st_q.cap.hs};

    generate
        for (genvar g = 0; g < N_SYNC; g++) begin : g_pol
            sync_pol_meas #(.MEAS_W(MEAS_W)) i_meas (
                .clk   (clk),
                .rst_n (rst_n),
                .sync_i(raw_sync[g]),
                .pol_o (pol[g])
            );
        end
    endgenerate

    assign hs_n = st_q.cap.hs ^ pol[0];
    assign vs_n = st_q.cap.vs ^ pol[1];

    raster_pos i_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .hs_n (hs_n),
        .vs_n (vs_n),
        .pos_o(pos_cur)
    );

    crop_window i_win (
        .pos_i (pos_cur),
        .x0    (cfg_x0),
        .w     (cfg_w),
        .y0    (cfg_y0),
        .h     (cfg_h),
        .in_win(win)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cap.vs   = in_vs;
        st_d.cap.hs   = in_hs;
        st_d.cap.de   = in_de;
        st_d.cap.pix  = in_pix;
        st_d.ext_de   = st_q.ext_de | st_q.cap.de;
        st_d.outb.vs  = vs_n;
        st_d.outb.hs  = hs_n;
        st_d.outb.pix = st_q.cap.pix;
        st_d.outb.de  = (st_q.ext_de | st_q.cap.de) ? st_q.cap.de : win;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vs     = st_q.outb.vs;
    assign out_hs     = st_q.outb.hs;
    assign out_de     = st_q.outb.de;
    assign out_pix    = st_q.outb.pix;
    assign det_hs_pol = pol[0];
    assign det_vs_pol = pol[1];

    // R6: once pass-through is entered it stays until reset
    assert_ext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext_de |=> st_q.ext_de);
    // R6: in pass-through mode the output DE mirrors the captured source DE
    assert_ext_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext_de |=> (out_de == $past(st_q.cap.de)));
    // R5: window mode never raises DE above the first row
    assert_win_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ext_de && !st_q.cap.de && pos_cur.y < cfg_y0) |=> !out_de);
    // R7: pixel data is the captured beat one stage later
    assert_pix_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_pix == $past(st_q.cap.pix)));
endmodule

// File: tb/test_vid_sync_crop.sv
module test_vid_sync_crop;
    import vsc_pkg::*;

    localparam int DAT_W = 24;
    localparam int HT = 20, HSW = 3, VT = 12, VSW = 2, FRAMES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vs = 1'b0, in_hs = 1'b0, in_de = 1'b0;
    logic [DAT_W-1:0] in_pix = '0;
    logic [POS_W-1:0] cfg_x0 = '0, cfg_w = '0, cfg_y0 = '0, cfg_h = '0;
    logic out_vs, out_hs, out_de, det_vs_pol, det_hs_pol;
    logic [DAT_W-1:0] out_pix;

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vid_sync_crop #(.DAT_W(DAT_W)) i_vid_sync_crop (
        .clk(clk), .rst_n(rst_n), .in_vs(in_vs), .in_hs(in_hs), .in_de(in_de),
        .in_pix(in_pix), .cfg_x0(cfg_x0), .cfg_w(cfg_w), .cfg_y0(cfg_y0),
        .cfg_h(cfg_h), .out_vs(out_vs), .out_hs(out_hs), .out_de(out_de),
        .out_pix(out_pix), .det_vs_pol(det_vs_pol), .det_hs_pol(det_hs_pol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ext: source DE present and shaped unlike the window
    task automatic run_pattern(input bit hp, input bit vp, input bit ext,
                               input int sx, input int w, input int sy, input int h);
        logic [DAT_W+3:0] e0 = '0, e1 = '0;
        bit v0 = 1'b0, v1 = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; in_hs = hp; in_vs = vp; in_de = 1'b0;
        cfg_x0 = POS_W'(sx); cfg_w = POS_W'(w); cfg_y0 = POS_W'(sy); cfg_h = POS_W'(h);
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 syncs", {30'd0, out_vs, out_hs}, 32'd0);
        chk("R8 de/pix", {7'd0, out_de, out_pix}, 32'd0);
        chk("R8 pol", {30'd0, det_vs_pol, det_hs_pol}, 32'd0);
        rst_n = 1'b1;
        for (int f = 0; f < FRAMES; f++) begin
            for (int l = 0; l < VT; l++) begin
                for (int c = 0; c < HT; c++) begin
                    bit nh, nv, de, ede;
                    logic [DAT_W-1:0] px;
                    if (v1) begin
                        chk("R1 out_hs", {31'd0, out_hs}, {31'd0, e1[DAT_W+1]});
                        chk("R1 out_vs", {31'd0, out_vs}, {31'd0, e1[DAT_W+2]});
                        chk(ext ? "R6 de pass" : "R5 de window",
                            {31'd0, out_de}, {31'd0, e1[DAT_W]});
                        chk("R7 pix", {8'd0, out_pix}, {8'd0, e1[DAT_W-1:0]});
                    end
                    nh  = (c < HSW);
                    nv  = (l < VSW);
                    ede = (l >= 4 && l < 9 && c >= 2 && c < 15);
                    // R3/R4 position = (c,l); R5 inclusive/exclusive bounds
                    de  = ext ? ede : (c >= sx && c < sx + w && l >= sy && l < sy + h);
                    px  = DAT_W'((f * VT + l) * HT + c + 24'h5A0000);
                    in_hs  = nh ^ hp;
                    in_vs  = nv ^ vp;
                    in_de  = ext ? ede : 1'b0;
                    in_pix = px;
                    e1 = e0; v1 = v0;
                    e0 = {1'b0, nv, nh, de, px};
                    v0 = (f >= 2);
                    @(negedge clk);
                end
            end
        end
        chk("R2 hs pol", {31'd0, det_hs_pol}, {31'd0, hp});
        chk("R2 vs pol", {31'd0, det_vs_pol}, {31'd0, vp});
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        // R1/R2: all four polarity combinations, R3/R4/R5 window
        run_pattern(1'b0, 1'b0, 1'b0, 4, 8, 3, 5);
        run_pattern(1'b1, 1'b0, 1'b0, 4, 8, 3, 5);
        run_pattern(1'b0, 1'b1, 1'b0, 4, 8, 3, 5);
        run_pattern(1'b1, 1'b1, 1'b0, 4, 8, 3, 5);
        // R5 boundaries: column 0, one column wide, last row
        run_pattern(1'b0, 1'b1, 1'b0, 0, 1, VT - 1, 1);
        run_pattern(1'b1, 1'b0, 1'b0, HT - 1, 1, 0, 1);
        // R6: source DE takes over, then reset restores window mode
        run_pattern(1'b1, 1'b1, 1'b1, 4, 8, 3, 5);
        run_pattern(1'b0, 1'b0, 1'b0, 2, 5, 6, 4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule